// File: doc/BRIEF.md
# Systolic 4x4 Matrix Multiplier

This block multiplies two square matrices of unsigned 8-bit elements on a grid of multiply-accumulate cells. Rows of the left matrix enter at the left edge, one lane per row. Columns of the right matrix enter at the top edge, one lane per column. On every strobe of `step_en`, each cell multiplies the two operands it currently holds and adds the product to its running sum. It then hands its left operand to the cell on its right and its top operand to the cell below it. While `step_en` is low, nothing in the array moves.

The feeder sends each lane as a seven-slot stream. Lane i is held back by i slots, so slots before i are leading padding. The four matrix elements follow, and the stream ends with zero padding. A job is thirteen strobes long: seven strobes carry the streams and six flush strobes let the wavefront reach the far corner. During the flush strobes the array feeds zeros into the edge cells itself. Each cell counts seven steps, starting from the step at which its first real operand pair arrives. It then latches its 32-bit dot product and raises its own valid flag. When all sixteen flags are high, `all_done` is asserted. The next strobe after that starts a new job.

Top module: `sysarr_mm`

## Requirements
- R1: While `rst` is high and directly after it, every cell valid flag, `all_done` and every result word is zero.
- R2: After a complete job, result word (i,j) at bits (i*4+j)*32 +: 32 equals the unsigned sum over k of A[i][k]*B[k][j].
- R3: Edge lanes are sampled on strobes 0 to 6 of a job. At strobe s, left lane i (bits i*8 +: 8 of `a_edge`) carries A[i][s-i] and top lane j (bits j*8 +: 8 of `b_edge`) carries B[s-j][j] when that index lies in 0..3.
- R4: Values on `a_edge` and `b_edge` during strobes 7 to 12 of a job have no effect on any result.
- R5: Cell (i,j) raises its valid flag (bit i*4+j of `cell_valid`) on the edge of strobe i+j+6 of the job. A cell with a left neighbour is never valid while that neighbour is not.
- R6: `all_done` goes high on the edge of strobe 12, the thirteenth strobe of a job, and not before.
- R7: A clock edge with `step_en` low changes no flag and no result word.
- R8: The first strobe of a new job clears every valid flag. Each result word keeps its previous value until that cell latches its new sum.
- R9: Leading padding slots (slot s below i on left lane i, slot s below j on top lane j) have no effect on any result, whatever values they carry.
- R10: Full-scale inputs (every element 255) give 260100 in every word, without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Step strobe; advances the whole array by one step |
| a_edge | input | 32 | Left-edge operands, 8 bits per row lane |
| b_edge | input | 32 | Top-edge operands, 8 bits per column lane |
| result | output | 512 | Sixteen 32-bit dot products, word (i,j) at index i*4+j |
| cell_valid | output | 16 | Per-cell result-valid flags |
| all_done | output | 1 | High when all cells hold valid results |

## Verification
The hardest case to reach from the ports is the overlap of two jobs. During this overlap the near corner has already latched new sums while the far corner still shows the previous job's words. The bench therefore runs back-to-back jobs and checks both corners at the start of the second job and midway through it. Junk values go into the leading padding slots and onto the flush strobes, so that only the slot gating keeps the sums correct. Idle gaps inserted inside a job show that the wavefront waits for the strobe and does not run on the clock.

// File: rtl/sysarr_mm.sv
`timescale 1ns/1ps
module sysarr_mm #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int OW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [N*DW-1:0]   a_edge,
  input  logic [N*DW-1:0]   b_edge,
  output logic [N*N*OW-1:0] result,
  output logic [N*N-1:0]    cell_valid,
  output logic              all_done
);
  localparam int SLEN   = 2*N - 1;
  localparam int JOBLEN = SLEN + 2*(N-1);
  localparam int SW     = $clog2(JOBLEN);
  localparam int PW     = 2*DW;
  localparam longint MAXSUM = longint'(N) * ((longint'(1) << DW) - 1) * ((longint'(1) << DW) - 1);

  logic [SW-1:0] step;
  logic          edge_live;

  assign edge_live = (step < SW'(SLEN));

  always_ff @(posedge clk) begin
    if (rst)
      step <= '0;
    else if (step_en)
      step <= (step == SW'(JOBLEN-1)) ? '0 : step + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_r
    for (genvar j = 0; j < N; j++) begin : g_c
      localparam int FIRST = i + j;
      localparam int LAST  = i + j + SLEN - 1;
      logic [DW-1:0] a_in, b_in, a_q, b_q;
      logic [PW-1:0] prod;
      logic [OW-1:0] acc, res;
      logic          vld;

      if (j == 0) begin : g_ain
        assign a_in = edge_live ? a_edge[i*DW +: DW] : '0;
      end else begin : g_ain
        assign a_in = g_r[i].g_c[j-1].a_q;
      end

      if (i == 0) begin : g_bin
        assign b_in = edge_live ? b_edge[j*DW +: DW] : '0;
      end else begin : g_bin
        assign b_in = g_r[i-1].g_c[j].b_q;
      end

      assign prod = PW'(a_in) * PW'(b_in);

      always_ff @(posedge clk) begin
        if (rst) begin
          a_q <= '0;
          b_q <= '0;
          acc <= '0;
          res <= '0;
          vld <= 1'b0;
        end else if (step_en) begin
          a_q <= a_in;
          b_q <= b_in;
          acc <= (step == SW'(FIRST)) ? OW'(prod) : acc + OW'(prod);
          if (step == SW'(LAST)) begin
            res <= acc + OW'(prod);
            vld <= 1'b1;
          end else if (step == '0) begin
            vld <= 1'b0;
          end
        end
      end

      assign result[(i*N+j)*OW +: OW] = res;
      assign cell_valid[i*N+j]        = vld;

      if (j > 0) begin : g_chk_order
        assert_wave_order_R5: assert property (@(posedge clk) disable iff (rst)
          vld |-> g_r[i].g_c[j-1].vld);
      end

      assert_sum_bound_R2: assert property (@(posedge clk) disable iff (rst)
        vld |-> (longint'(res) <= MAXSUM));
    end
  end

  assign all_done = &cell_valid;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cell_valid == '0 && result == '0 && step == '0));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(cell_valid) && $stable(result)));

  assert_job_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (step_en && step == '0) |=> (cell_valid == '0));

  assert_done_edge_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(all_done) |-> ($past(step_en) && step == '0));
endmodule

// File: tb/tb_sysarr_mm.sv
`timescale 1ns/1ps
module tb_sysarr_mm;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst;
  logic step_en;
  logic [N*8-1:0] a_edge, b_edge;
  logic [N*N*32-1:0] result;
  logic [N*N-1:0] cell_valid;
  logic all_done;

  int total = 0;
  int bad = 0;
  int unsigned ma [N][N];
  int unsigned mb [N][N];
  longint expv [N*N];
  longint oldv [N*N];

  always #2.5 clk = ~clk;

  sysarr_mm dut (
    .clk(clk), .rst(rst), .step_en(step_en),
    .a_edge(a_edge), .b_edge(b_edge),
    .result(result), .cell_valid(cell_valid), .all_done(all_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic longint word(input int idx);
    return longint'(result[idx*32 +: 32]);
  endfunction

  task automatic compute_expected();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        longint s = 0;
        for (int k = 0; k < N; k++) s += longint'(ma[i][k]) * longint'(mb[k][j]);
        expv[i*N+j] = s;
      end
  endtask

  function automatic logic [N*N-1:0] mask_after(input int s);
    logic [N*N-1:0] m = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        m[i*N+j] = (s >= i + j + 6);
    return m;
  endfunction

  task automatic run_job(input bit lead_junk, input bit flush_junk, input bit gaps, input bit overlap);
    for (int x = 0; x < N*N; x++) oldv[x] = word(x);
    compute_expected();
    for (int s = 0; s < 13; s++) begin
      for (int i = 0; i < N; i++) begin
        int k = s - i;
        int unsigned av, bv;
        av = (s < 7 && k >= 0 && k < N) ? ma[i][k] : 0;
        bv = (s < 7 && k >= 0 && k < N) ? mb[k][i] : 0;
        if (lead_junk && s < i) begin av = $urandom % 256; bv = $urandom % 256; end
        if (flush_junk && s >= 7) begin av = $urandom % 256; bv = $urandom % 256; end
        a_edge[i*8 +: 8] = av[7:0];
        b_edge[i*8 +: 8] = bv[7:0];
      end
      step_en = 1'b1;
      @(negedge clk);
      step_en = 1'b0;
      chk(cell_valid == mask_after(s), "R5 cell flags", longint'(cell_valid), longint'(mask_after(s)));
      chk(all_done == (s == 12), "R6 all_done", longint'(all_done), longint'(s == 12));
      if (overlap && s == 0) begin
        chk(cell_valid == '0, "R8 flags cleared", longint'(cell_valid), 0);
        chk(word(0) == oldv[0], "R8 word0 held", word(0), oldv[0]);
        chk(word(15) == oldv[15], "R8 word15 held", word(15), oldv[15]);
      end
      if (overlap && s == 6) begin
        chk(word(0) == expv[0], "R8 word0 new", word(0), expv[0]);
        chk(word(15) == oldv[15], "R8 word15 old", word(15), oldv[15]);
      end
      if (gaps && (s % 3 == 1)) begin
        logic [N*N-1:0] fv = cell_valid;
        logic [N*N*32-1:0] rv = result;
        for (int g = 0; g < 2; g++) begin
          a_edge = $urandom;
          b_edge = $urandom;
          @(negedge clk);
        end
        chk(cell_valid == fv, "R7 flags idle", longint'(cell_valid), longint'(fv));
        chk(result == rv, "R7 results idle", longint'(result[31:0]), longint'(rv[31:0]));
      end
    end
    for (int x = 0; x < N*N; x++)
      chk(word(x) == expv[x], "R2 R3 dot product", word(x), expv[x]);
  endtask

  task automatic rand_mats();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = $urandom % 256;
        mb[i][j] = $urandom % 256;
      end
  endtask

  task automatic test_reset();
    rst = 1'b1; step_en = 1'b0; a_edge = '0; b_edge = '0;
    repeat (3) @(negedge clk);
    chk(cell_valid == '0 && !all_done, "R1 flags in reset", longint'(cell_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(result == '0, "R1 results zero", longint'(result[31:0]), 0);
    chk(cell_valid == '0 && !all_done, "R1 flags after reset", longint'(cell_valid), 0);
  endtask

  task automatic test_basic();
    rand_mats();
    run_job(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic test_overlap();
    rand_mats();
    run_job(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic test_flush_junk_R4();
    rand_mats();
    run_job(1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic test_lead_junk_R9();
    rand_mats();
    run_job(1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic test_gaps_R7();
    rand_mats();
    run_job(1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic test_full_scale_R10();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 255;
        mb[i][j] = 255;
      end
    run_job(1'b0, 1'b0, 1'b0, 1'b1);
    chk(word(5) == 260100, "R10 full scale", word(5), 260100);
  endtask

  initial begin
    test_reset();
    test_basic();
    test_overlap();
    test_flush_junk_R4();
    test_lead_junk_R9();
    test_gaps_R7();
    test_full_scale_R10();
    test_basic();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule